// File: doc/BRIEF.md
# Buck Charger Start-Up Sequencer

This block brings a synchronous buck battery charger from rest to regulated operation when its output is already held up by a battery. The start is enabled only while both an external start command and a panel-voltage-good flag are high. Whichever of the two rises last starts the sequence. The block first turns the low-side switch on for a short, fixed time to charge the high-side bootstrap capacitor. It then searches for a usable regulation set point: it steps the set-point DAC code upward from zero until the feedback comparator changes state.

The code it finds is reduced by a fixed back-off amount and becomes the starting set point. The block then enables the PWM with the low-side gate off, so freewheel current flows through the diode and cannot be drawn back out of the battery. During this phase the maximum duty limit ramps up from zero. Once the ramp completes, the block holds the full limit. From the soft-start phase onward, an outer regulation loop may load new set-point codes. The measured battery current switches between synchronous and diode rectification, with separate thresholds for entering and leaving synchronous mode.

If the search reaches full scale without a comparator change, the block stops in a fault state. If either enable input drops at any time, the block returns to rest.

Top module: `buck_startup_seq`

## Requirements
- R1: After reset, ls_gate_en, pwm_run, fault and duty_max are 0 and dac_code is 0.
- R2: From idle, the sequence starts on the first clock edge at which start_req and panel_ok are both high, whichever of them rose last; in the next cycle ls_gate_en is 1.
- R3: Bootstrap precharge holds ls_gate_en at 1 with pwm_run at 0 for exactly PRECHG_CYC cycles.
- R4: The search drives dac_code 0, 1, 2, ... with each code held for STEP_CYC cycles. In the last cycle of each dwell, comp_in is compared with the value it had in the last precharge cycle. The search stops at the first code for which the two differ.
- R5: When the search stops at code K, dac_code becomes max(K - BACKOFF, 0) in the same cycle that pwm_run first goes to 1.
- R6: If code 2^DAC_W-1 completes its dwell with no comparator change, fault goes to 1 with ls_gate_en, pwm_run and duty_max at 0. This state holds until start_req or panel_ok drops, after which fault is 0.
- R7: Soft start begins with pwm_run at 1, ls_gate_en at 0 and duty_max at 0. duty_max rises by one every RAMP_CYC cycles and never falls. It then holds at DUTY_LIM.
- R8: While pwm_run is 1, a cycle with dac_load at 1 makes dac_code equal dac_load_val in the next cycle. In idle, a dac_load pulse leaves dac_code at 0.
- R9: While pwm_run is 1, ls_gate_en goes to 1 in the cycle after ibat > I_ON (strictly greater) is seen. It goes to 0 in the cycle after ibat < I_OFF (strictly less) is seen. Otherwise it keeps its value.
- R10: When start_req or panel_ok is 0, ls_gate_en, pwm_run and duty_max are 0 in that same cycle. After the next edge the block is idle with dac_code 0, and a later start begins again from precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start command, level |
| panel_ok | input | 1 | Panel voltage high enough to charge |
| comp_in | input | 1 | Feedback comparator output |
| ibat | input | IBAT_W | Battery current measurement |
| dac_load | input | 1 | Outer loop set-point load strobe |
| dac_load_val | input | DAC_W | Outer loop set-point value |
| dac_code | output | DAC_W | Set-point DAC code |
| ls_gate_en | output | 1 | Low-side gate enable |
| pwm_run | output | 1 | PWM generator enable |
| duty_max | output | DUTY_W | Maximum duty limit |
| fault | output | 1 | Search found no comparator change |

## Verification
Two events can fall into the same clock edge: an abort, when panel_ok drops, and the comparator change that ends the search. The bench models the comparator as a threshold on dac_code, so it knows the code at which the search will stop. It counts cycles from the end of precharge to the last dwell cycle of that code and drops panel_ok there. The abort must win. The outputs go low at once, pwm_run must not appear at the next sample, dac_code must read 0, and a new start must run a full precharge again.

// File: rtl/buck_startup_seq.sv
module buck_startup_seq #(
  parameter int DAC_W      = 8,
  parameter int DUTY_W     = 8,
  parameter int IBAT_W     = 10,
  parameter int PRECHG_CYC = 8,
  parameter int STEP_CYC   = 4,
  parameter int BACKOFF    = 3,
  parameter int RAMP_CYC   = 2,
  parameter int DUTY_LIM   = 200,
  parameter int I_ON       = 300,
  parameter int I_OFF      = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              panel_ok,
  input  logic              comp_in,
  input  logic [IBAT_W-1:0] ibat,
  input  logic              dac_load,
  input  logic [DAC_W-1:0]  dac_load_val,
  output logic [DAC_W-1:0]  dac_code,
  output logic              ls_gate_en,
  output logic              pwm_run,
  output logic [DUTY_W-1:0] duty_max,
  output logic              fault
);
  localparam int CMAX  = (PRECHG_CYC > STEP_CYC) ? ((PRECHG_CYC > RAMP_CYC) ? PRECHG_CYC : RAMP_CYC)
                                                 : ((STEP_CYC > RAMP_CYC) ? STEP_CYC : RAMP_CYC);
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [DAC_W-1:0]  DAC_TOP = {DAC_W{1'b1}};
  localparam logic [DAC_W-1:0]  BACK    = DAC_W'(BACKOFF);
  localparam logic [DUTY_W-1:0] DLIM    = DUTY_W'(DUTY_LIM);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SWEEP, S_SOFT, S_RUN, S_FAULT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [DAC_W-1:0]  dac_q;
  logic [DUTY_W-1:0] duty_q;
  logic              sync_q, comp_ref;

  wire active   = start_req & panel_ok;
  wire running  = (st == S_SOFT) || (st == S_RUN);
  wire last_pre = cnt == CNT_W'(PRECHG_CYC - 1);
  wire last_stp = cnt == CNT_W'(STEP_CYC - 1);
  wire last_rmp = cnt == CNT_W'(RAMP_CYC - 1);
  wire hi_cur   = 32'(ibat) > I_ON;
  wire lo_cur   = 32'(ibat) < I_OFF;

  assign dac_code   = dac_q;
  assign ls_gate_en = active & ((st == S_PRE) | (running & sync_q));
  assign pwm_run    = active & running;
  assign duty_max   = (active & running) ? duty_q : '0;
  assign fault      = st == S_FAULT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; dac_q <= '0; duty_q <= '0; sync_q <= 1'b0; comp_ref <= 1'b0;
    end else if (!active) begin
      st <= S_IDLE; cnt <= '0; dac_q <= '0; duty_q <= '0; sync_q <= 1'b0;
    end else begin
      if (running) begin
        if (dac_load) dac_q <= dac_load_val;
        if (!sync_q && hi_cur) sync_q <= 1'b1;
        else if (sync_q && lo_cur) sync_q <= 1'b0;
      end
      case (st)
        S_IDLE: begin
          st <= S_PRE; cnt <= '0;
        end
        S_PRE: begin
          if (last_pre) begin
            st <= S_SWEEP; cnt <= '0; dac_q <= '0; comp_ref <= comp_in;
          end else cnt <= cnt + 1'b1;
        end
        S_SWEEP: begin
          if (last_stp) begin
            cnt <= '0;
            if (comp_in != comp_ref) begin
              st <= S_SOFT; duty_q <= '0;
              dac_q <= (dac_q > BACK) ? dac_q - BACK : '0;
            end else if (dac_q == DAC_TOP) st <= S_FAULT;
            else dac_q <= dac_q + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_SOFT: begin
          if (last_rmp) begin
            cnt <= '0;
            if (duty_q >= DLIM - 1'b1) begin
              duty_q <= DLIM; st <= S_RUN;
            end else duty_q <= duty_q + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_precharge_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |-> (cnt < CNT_W'(PRECHG_CYC)));
  assert_backoff_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFT && $past(st) == S_SWEEP) |-> (dac_q <= $past(dac_q)));
  assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT) |-> (!ls_gate_en && !pwm_run && duty_max == '0));
  assert_ramp_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOFT && $past(st) == S_SOFT) |-> (duty_q >= $past(duty_q)));
  assert_sync_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> (32'($past(ibat)) > I_ON));
  assert_sync_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) && $past(active) |-> (32'($past(ibat)) < I_OFF));
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st == S_IDLE && dac_q == '0));
endmodule

// File: tb/tb_buck_startup_seq.sv
module tb_buck_startup_seq;
  localparam int DAC_W = 8, DUTY_W = 8, IBAT_W = 10;
  localparam int PRECHG_CYC = 8, STEP_CYC = 4, BACKOFF = 3, RAMP_CYC = 2;
  localparam int DUTY_LIM = 200, I_ON = 300, I_OFF = 200;

  logic clk = 0, rst_n = 0, start_req = 0, panel_ok = 0, dac_load = 0;
  logic [IBAT_W-1:0] ibat = '0;
  logic [DAC_W-1:0] dac_load_val = '0;
  logic [DAC_W-1:0] dac_code;
  logic ls_gate_en, pwm_run, fault, comp_in;
  logic [DUTY_W-1:0] duty_max;
  int thr = 1000;
  int checks = 0, errors = 0;

  assign comp_in = 32'(dac_code) >= thr;

  always #10 clk = ~clk;

  buck_startup_seq #(.DAC_W(DAC_W), .DUTY_W(DUTY_W), .IBAT_W(IBAT_W), .PRECHG_CYC(PRECHG_CYC),
    .STEP_CYC(STEP_CYC), .BACKOFF(BACKOFF), .RAMP_CYC(RAMP_CYC), .DUTY_LIM(DUTY_LIM),
    .I_ON(I_ON), .I_OFF(I_OFF)) dut (.*);

  function automatic int exp_start(int k);
    return (k > BACKOFF) ? k - BACKOFF : 0;
  endfunction

  function automatic bit next_sync(bit s, int i);
    if (!s && i > I_ON) return 1'b1;
    if (s && i < I_OFF) return 1'b0;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic stop_all();
    start_req = 0; panel_ok = 0; ibat = '0; tick();
  endtask

  task automatic launch(int t);
    int n = 0;
    thr = t;
    start_req = 1; panel_ok = 1;
    tick();
    while (ls_gate_en && !pwm_run && n < 1000) begin n++; tick(); end
    chk("R3 precharge width", n, PRECHG_CYC);
  endtask

  task automatic reach_soft(int t);
    int n = 0;
    launch(t);
    while (!pwm_run && !fault && n < 3000) begin n++; tick(); end
    chk("R5 pwm_run up", pwm_run, 1);
    chk("R5 start code", dac_code, exp_start(t));
    chk("R7 soft duty0", duty_max, 0);
    chk("R7 soft ls off", ls_gate_en, 0);
  endtask

  task automatic finish_ramp();
    int prev = 0;
    bit mono = 1;
    repeat (RAMP_CYC * DUTY_LIM + 4) begin
      tick();
      if (duty_max < prev) mono = 0;
      prev = duty_max;
    end
    chk("R7 ramp monotonic", mono, 1);
    chk("R7 ramp final", duty_max, DUTY_LIM);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 ls", ls_gate_en, 0); chk("R1 pwm", pwm_run, 0);
    chk("R1 duty", duty_max, 0); chk("R1 dac", dac_code, 0); chk("R1 fault", fault, 0);

    dac_load_val = 8'd77; dac_load = 1; tick(); dac_load = 0; tick();
    chk("R8 idle load ignored", dac_code, 0);

    panel_ok = 1; tick();
    chk("R2 panel only no start", ls_gate_en, 0);
    thr = 10;
    start_req = 1; tick();
    chk("R2 start after both", ls_gate_en, 1);
    stop_all();

    reach_soft(10);
    tick(); tick();
    chk("R7 first step", duty_max, 1);
    finish_ramp();
    dac_load_val = 8'd123; dac_load = 1; tick(); dac_load = 0;
    chk("R8 load", dac_code, 123);
    ibat = 10'(I_ON); tick(); tick();
    chk("R9 equal on no sync", ls_gate_en, 0);
    ibat = 10'(I_ON + 1); tick();
    chk("R9 enter sync", ls_gate_en, 1);
    ibat = 10'(I_OFF); tick(); tick();
    chk("R9 equal off holds", ls_gate_en, 1);
    ibat = 10'(I_OFF - 1); tick();
    chk("R9 exit sync", ls_gate_en, 0);
    ibat = 10'(I_ON + 50); tick();
    panel_ok = 0; #1;
    chk("R10 ls same cycle", ls_gate_en, 0);
    chk("R10 pwm same cycle", pwm_run, 0);
    chk("R10 duty same cycle", duty_max, 0);
    tick();
    chk("R10 dac idle", dac_code, 0);
    ibat = '0; start_req = 0; tick();

    reach_soft(2);
    stop_all();

    start_req = 1; tick(); tick();
    chk("R2 start-first no run", ls_gate_en, 0);
    reach_soft(40);
    stop_all();

    launch(1000);
    repeat (256 * STEP_CYC + 4) tick();
    chk("R6 fault", fault, 1);
    chk("R6 ls", ls_gate_en, 0); chk("R6 pwm", pwm_run, 0); chk("R6 duty", duty_max, 0);
    repeat (20) tick();
    chk("R6 fault held", fault, 1);
    start_req = 0; tick(); tick();
    chk("R6 fault cleared", fault, 0);
    stop_all();

    launch(0);
    repeat (256 * STEP_CYC + 4) tick();
    chk("R4 comparator already high gives fault", fault, 1);
    stop_all();

    launch(20);
    repeat (20 * STEP_CYC + STEP_CYC - 1) tick();
    chk("R4 still sweeping", pwm_run, 0);
    panel_ok = 0; #1;
    chk("R10 abort on hit ls", ls_gate_en, 0);
    tick();
    chk("R10 abort beats hit pwm", pwm_run, 0);
    chk("R10 abort beats hit dac", dac_code, 0);
    start_req = 0; tick();
    launch(20);
    stop_all();

    for (int r = 0; r < 8; r++) begin
      int t = $urandom_range(1, 255);
      bit s = 0;
      reach_soft(t);
      finish_ramp();
      for (int k = 0; k < 40; k++) begin
        int i = $urandom_range(0, 500);
        ibat = 10'(i);
        tick();
        s = next_sync(s, i);
        chk("R9 random sync", ls_gate_en, s);
      end
      stop_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule